// File: doc/BRIEF.md
# Flash Program/Erase Mode Controller

This block decides which operations an on-chip flash array may perform at any moment. It follows the program and erase request bits of a control register and the level of the write-enable pin, and from these it grants permission flags for plain reads, verify-reads, programming and erasing. It also raises a mask that holds off the non-maskable interrupt while a write operation is under way.

An error strobe seen during programming or erasing moves the block into a sticky error-protection condition. In that condition the error flag stays high and only plain reads remain allowed. Entering software standby from error protection moves to a standby sub-state that keeps the flag high and holds the registers initialized. Leaving standby returns to error protection, not to normal operation. Only a synchronous reset or hardware standby clears the error and puts the block back in hardware protection. The array timing, the charge pumps, the bus interface and the boot loader are not part of this block.

Top module: `flash_mode_ctrl`

## Requirements
- R1: While `rst_n` is low or `hw_stby` is high at a rising edge, from any state, the block enters hardware protection after that edge. In hardware protection `rd_ok`, `vf_ok`, `pr_ok`, `er_ok` and `nmi_mask` are 0, `reg_init` is 1 and `fler` is 0.
- R2: One edge after hardware protection with `rst_n` high and `hw_stby` low, the block is in read/verify. There `rd_ok`=1, `vf_ok`=1, `pr_ok`=0, `er_ok`=0, `reg_init`=0 and `fler`=0.
- R3: From read/verify with `fwe` high, `prog_bit`=1 enters program mode on the next edge (`pr_ok`=1, `vf_ok`=1, `rd_ok`=0). `erase_bit`=1 enters erase mode (`er_ok`=1, `vf_ok`=1, `rd_ok`=0).
- R4: When `prog_bit` and `erase_bit` are both 1 in read/verify, program mode is entered and the erase request is ignored.
- R5: With `fwe` low, the read/verify state ignores both request bits. In program or erase mode, `pr_ok` and `er_ok` read 0 while `fwe` is low.
- R6: Program or erase mode returns to read/verify on the edge where `prog_bit` and `erase_bit` are both 0. While either bit is 1, the mode is kept.
- R7: `err_det` high at an edge in program or erase mode moves the block to error protection, and `fler` goes to 1 on that same edge. This takes priority over a return to read/verify. Error protection gives `rd_ok`=1 and `vf_ok`=`pr_ok`=`er_ok`=0. `err_det` has no effect in read/verify or hardware protection.
- R8: `sw_stby` high in error protection enters the standby error sub-state (`fler`=1, `reg_init`=1, all permissions 0). `sw_stby` low there returns to error protection. `sw_stby` has no effect in the other states.
- R9: Once set, `fler` stays 1 and the block stays in the error states whatever the request bits do, until R1 applies.
- R10: `nmi_mask` is 1 exactly while the block is in program or erase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_stby | input | 1 | Hardware standby request, forces hardware protection |
| sw_stby | input | 1 | Software standby level (1 = in standby) |
| fwe | input | 1 | Write-enable pin level |
| prog_bit | input | 1 | Program request bit |
| erase_bit | input | 1 | Erase request bit |
| err_det | input | 1 | Error-detect strobe, sampled on the rising edge |
| rd_ok | output | 1 | Plain memory read allowed |
| vf_ok | output | 1 | Verify-read allowed |
| pr_ok | output | 1 | Programming allowed |
| er_ok | output | 1 | Erasing allowed |
| reg_init | output | 1 | Control registers held in their initialized state |
| fler | output | 1 | Sticky error flag |
| nmi_mask | output | 1 | Non-maskable interrupt input masked |

## Verification
The properties assume every input is a clean level that is stable around the rising edge. They also assume `hw_stby` and `rst_n` act only as whole-cycle levels, so that one sampled value decides each transition. The stimulus changes inputs only on the falling edge and holds each pattern for at least one full cycle. The error strobe is pulsed in program, erase and read/verify alike, so that its gating by state is exercised rather than assumed.

// File: rtl/fmc_pkg.sv
// Package: shared state encoding and permission bundle for the flash
// mode controller. Assumes a single clock domain.
package fmc_pkg;

    typedef enum logic [2:0] {
        FM_HWPROT   = 3'd0,
        FM_READ     = 3'd1,
        FM_PROG     = 3'd2,
        FM_ERASE    = 3'd3,
        FM_ERR      = 3'd4,
        FM_ERR_STBY = 3'd5
    } fm_state_e;

    typedef struct packed {
        logic rd;
        logic vf;
        logic pr;
        logic er;
        logic init;
    } fm_perm_t;

endpackage

// File: rtl/fmc_next_state.sv
// Module: next-state logic of the mode controller. It is pure combinational
// logic. Reset and hardware standby are applied by the state register in the
// parent and are not seen here. Assumes inputs are synchronous levels.
module fmc_next_state
    import fmc_pkg::*;
(
    input  fm_state_e cur,
    input  logic      prog_req,
    input  logic      erase_req,
    input  logic      wen,
    input  logic      err_strobe,
    input  logic      stby,
    output fm_state_e nxt,
    output logic      err_set
);

    // Purpose: choose the following mode and flag the error-entry edge.
    always_comb begin
        nxt     = cur;
        err_set = 1'b0;
        unique case (cur)
            FM_HWPROT: nxt = FM_READ;
            FM_READ: begin
                if (wen && prog_req)       nxt = FM_PROG;
                else if (wen && erase_req) nxt = FM_ERASE;
            end
            FM_PROG, FM_ERASE: begin
                if (err_strobe) begin
                    nxt     = FM_ERR;
                    err_set = 1'b1;
                end else if (!prog_req && !erase_req) begin
                    nxt = FM_READ;
                end
            end
            FM_ERR:      if (stby)  nxt = FM_ERR_STBY;
            FM_ERR_STBY: if (!stby) nxt = FM_ERR;
            default:     nxt = FM_HWPROT;
        endcase
    end

endmodule

// File: rtl/fmc_sticky_err.sv
// Module: sticky error flag. It is set on the error-entry edge and cleared
// only by reset or hardware standby. Assumes set is a single-cycle request
// from the next-state logic.
module fmc_sticky_err (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic flag
);

    // Purpose: hold the error flag across all error sub-states.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flag <= 1'b0;
        else if (set)      flag <= 1'b1;
    end

endmodule

// File: rtl/fmc_perm_decode.sv
// Module: decodes the current mode into permission flags and the interrupt
// mask. Write permissions are also gated by the write-enable pin level.
module fmc_perm_decode
    import fmc_pkg::*;
(
    input  fm_state_e cur,
    input  logic      wen,
    output fm_perm_t  perm,
    output logic      nmi_hold
);

    // Purpose: map each mode onto its allowed operations.
    always_comb begin
        perm     = '0;
        nmi_hold = 1'b0;
        unique case (cur)
            FM_HWPROT:   perm.init = 1'b1;
            FM_READ: begin
                perm.rd = 1'b1;
                perm.vf = 1'b1;
            end
            FM_PROG: begin
                perm.vf  = 1'b1;
                perm.pr  = wen;
                nmi_hold = 1'b1;
            end
            FM_ERASE: begin
                perm.vf  = 1'b1;
                perm.er  = wen;
                nmi_hold = 1'b1;
            end
            FM_ERR:      perm.rd   = 1'b1;
            FM_ERR_STBY: perm.init = 1'b1;
            default:     perm.init = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_mode_ctrl.sv
// Module: top of the flash program/erase mode controller. It holds the mode
// register and connects next-state, error flag and decode. Assumes a
// synchronous active-low reset; hardware standby acts like reset.
module flash_mode_ctrl
    import fmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_stby,
    input  logic sw_stby,
    input  logic fwe,
    input  logic prog_bit,
    input  logic erase_bit,
    input  logic err_det,
    output logic rd_ok,
    output logic vf_ok,
    output logic pr_ok,
    output logic er_ok,
    output logic reg_init,
    output logic fler,
    output logic nmi_mask
);

    fm_state_e state_q;
    fm_state_e state_d;
    logic      err_set;
    fm_perm_t  perm;

    fmc_next_state u_next (
        .cur        (state_q),
        .prog_req   (prog_bit),
        .erase_req  (erase_bit),
        .wen        (fwe),
        .err_strobe (err_det),
        .stby       (sw_stby),
        .nxt        (state_d),
        .err_set    (err_set)
    );

    // Purpose: mode register, forced to hardware protection by reset/standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) state_q <= FM_HWPROT;
        else                   state_q <= state_d;
    end

    fmc_sticky_err u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hw_stby),
        .set   (err_set),
        .flag  (fler)
    );

    fmc_perm_decode u_dec (
        .cur      (state_q),
        .wen      (fwe),
        .perm     (perm),
        .nmi_hold (nmi_mask)
    );

    assign rd_ok    = perm.rd;
    assign vf_ok    = perm.vf;
    assign pr_ok    = perm.pr;
    assign er_ok    = perm.er;
    assign reg_init = perm.init;

endmodule

// File: rtl/fmc_checker.sv
// Module: property checker for the flash mode controller, bound to the top.
module fmc_checker (
    input logic clk,
    input logic rst_n,
    input logic hw_stby,
    input logic sw_stby,
    input logic fwe,
    input logic prog_bit,
    input logic erase_bit,
    input logic err_det,
    input logic rd_ok,
    input logic vf_ok,
    input logic pr_ok,
    input logic er_ok,
    input logic reg_init,
    input logic fler,
    input logic nmi_mask
);

    AST_HWSTBY_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> reg_init && !fler && !rd_ok && !pr_ok && !er_ok && !nmi_mask); // R1

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pr_ok && er_ok)); // R4

    AST_WRITE_NEEDS_FWE: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_ok || er_ok) |-> fwe && nmi_mask); // R5

    AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_mask && err_det && !hw_stby) |=> fler && !nmi_mask); // R7

    AST_ERR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fler |-> !vf_ok && !pr_ok && !er_ok); // R7

    AST_STBY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fler && sw_stby && !hw_stby) |=> fler && reg_init && !rd_ok); // R8

    AST_FLER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fler && !hw_stby) |=> fler); // R9

    AST_NMI_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_mask |-> !fler && !reg_init && !rd_ok && vf_ok); // R10

endmodule

bind flash_mode_ctrl fmc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .fwe       (fwe),
    .prog_bit  (prog_bit),
    .erase_bit (erase_bit),
    .err_det   (err_det),
    .rd_ok     (rd_ok),
    .vf_ok     (vf_ok),
    .pr_ok     (pr_ok),
    .er_ok     (er_ok),
    .reg_init  (reg_init),
    .fler      (fler),
    .nmi_mask  (nmi_mask)
);

// File: tb/flash_mode_ctrl_bench.sv
module flash_mode_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, fwe = 1'b1;
    logic prog_bit = 1'b0, erase_bit = 1'b0, err_det = 1'b0;
    logic rd_ok, vf_ok, pr_ok, er_ok, reg_init, fler, nmi_mask;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference: 0 hw-prot, 1 read, 2 prog, 3 erase, 4 err, 5 err-stby
    int m_mode = 0;
    bit m_fler = 1'b0;

    always #4 clk = ~clk;

    flash_mode_ctrl u_flash_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .fwe(fwe), .prog_bit(prog_bit), .erase_bit(erase_bit), .err_det(err_det),
        .rd_ok(rd_ok), .vf_ok(vf_ok), .pr_ok(pr_ok), .er_ok(er_ok),
        .reg_init(reg_init), .fler(fler), .nmi_mask(nmi_mask)
    );

    task automatic model_edge();
        if (!rst_n || hw_stby) begin
            m_mode = 0;
            m_fler = 1'b0;
        end else begin
            case (m_mode)
                0: m_mode = 1;
                1: if (fwe && prog_bit) m_mode = 2;
                   else if (fwe && erase_bit) m_mode = 3;
                2, 3: if (err_det) begin
                          m_mode = 4;
                          m_fler = 1'b1;
                      end else if (!prog_bit && !erase_bit) m_mode = 1;
                4: if (sw_stby) m_mode = 5;
                5: if (!sw_stby) m_mode = 4;
                default: m_mode = 0;
            endcase
        end
    endtask

    function automatic logic [6:0] expected();
        logic [6:0] e;
        e[6] = (m_mode == 1) || (m_mode == 4);
        e[5] = (m_mode >= 1) && (m_mode <= 3);
        e[4] = (m_mode == 2) && fwe;
        e[3] = (m_mode == 3) && fwe;
        e[2] = (m_mode == 0) || (m_mode == 5);
        e[1] = m_fler;
        e[0] = (m_mode == 2) || (m_mode == 3);
        return e;
    endfunction

    // one clock: model follows the edge, outputs compared on the falling edge
    task automatic tick(input string req);
        logic [6:0] act;
        logic [6:0] exp_v;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        act   = {rd_ok, vf_ok, pr_ok, er_ok, reg_init, fler, nmi_mask};
        exp_v = expected();
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s: {rd,vf,pr,er,init,fler,nmi} actual %b expected %b",
                     req, act, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        tick("R1"); tick("R1");
        rst_n = 1'b1;
        tick("R2"); tick("R2");
        // R3 program entry, R6 hold while any bit set
        prog_bit = 1'b1; tick("R3"); tick("R10");
        erase_bit = 1'b1; tick("R6");
        prog_bit = 1'b0; tick("R6");
        erase_bit = 1'b0; tick("R6"); tick("R2");
        // R3 erase entry, R5 fwe gating in erase
        erase_bit = 1'b1; tick("R3");
        fwe = 1'b0; tick("R5"); tick("R5");
        fwe = 1'b1; tick("R3");
        erase_bit = 1'b0; tick("R6");
        // R4 both bits at once
        prog_bit = 1'b1; erase_bit = 1'b1; tick("R4"); tick("R4");
        prog_bit = 1'b0; erase_bit = 1'b0; tick("R6");
        // R5 fwe low blocks entry
        fwe = 1'b0; prog_bit = 1'b1; tick("R5");
        prog_bit = 1'b0; erase_bit = 1'b1; tick("R5");
        erase_bit = 1'b0; fwe = 1'b1; tick("R5");
        // R7 strobe ignored in read, R8 standby ignored in read
        err_det = 1'b1; tick("R7");
        err_det = 1'b0; sw_stby = 1'b1; tick("R8");
        sw_stby = 1'b0; tick("R8");
        // R7 error in program mode, R9 sticky, R8 standby sub-state
        prog_bit = 1'b1; tick("R3");
        err_det = 1'b1; tick("R7");
        err_det = 1'b0; prog_bit = 1'b0; tick("R9"); tick("R9");
        prog_bit = 1'b1; tick("R9");
        prog_bit = 1'b0; sw_stby = 1'b1; tick("R8"); tick("R8");
        sw_stby = 1'b0; tick("R8"); tick("R9");
        hw_stby = 1'b1; tick("R1"); tick("R1");
        hw_stby = 1'b0; tick("R2");
        // R7 error in erase with bits cleared on the same edge
        erase_bit = 1'b1; tick("R3");
        erase_bit = 1'b0; err_det = 1'b1; tick("R7");
        err_det = 1'b0; sw_stby = 1'b1; tick("R8");
        rst_n = 1'b0; tick("R1");
        rst_n = 1'b1; sw_stby = 1'b0; tick("R2");
        // R1 hardware standby from program mode
        prog_bit = 1'b1; tick("R10");
        hw_stby = 1'b1; tick("R1");
        hw_stby = 1'b0; tick("R2"); tick("R3");
        prog_bit = 1'b0; tick("R10");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule